// File: doc/BRIEF.md
# Fuse Shadow Refresh Sequencer

This block is a small bus master that sits beside a one-time-programmable fuse controller. After reset, or when a start pulse arrives while it is idle, it walks a fixed range of fuse words and, for each word that software has not locked against shadow reads, has the controller copy the fuse contents into the shadow register of that word. It talks to the controller through a plain register port: one access is presented at a time and completes in the cycle the grant input is high.

For every word the sequencer reads the lock bank, samples the array power bit, and powers the array up if it is off. It then issues the read command and waits for the busy bit to fall. Next it checks the disturbed and error flags of that word and, if it did the power-up itself, turns the array off again and waits for power to drop. Each wait is bounded by a cycle budget derived from the clock frequency. Flag errors are logged and the walk carries on. An expired wait ends the walk at once.

The outputs report completion, a sticky error flag, a two-bit code of the first problem seen and the index of the word where it arose.

Top module: `fuse_shadow_refresh`

## Requirements
- R1: The walk starts by itself once after reset and again on each `start` pulse seen while idle. `busy` is high for the whole walk and `done` rises when it ends and stays high until the next walk begins. A `start` pulse during a walk has no effect.
- R2: Words FIRST_WORD..LAST_WORD (57..95 by default) are visited once each in ascending order. The read command for a word is a write to the control register (offset 0x004) whose data holds the word index in its low bits, with bit 8 clear.
- R3: Before touching a word, the lock bank word at offset 0x094 + 4*(index/32) is read. If bit (index mod 32) is set, the word is skipped with no power access and no command.
- R4: Status (offset 0x00C) bit 5 reports array power. If it is clear before a command, the sequencer writes 1 to configuration (offset 0x000, bit 0) and waits for bit 5 to rise. After the word it writes 0 and waits for bit 5 to fall before moving on. If power was already on, no configuration write is made for that word.
- R5: After a command, status is polled until bit 3 (busy) reads clear. Only then are the flag banks read.
- R6: The disturbed bank (offset 0x01C + 4*(index/32)) is checked before the error bank (offset 0x034 + 4*(index/32)). A set disturbed bit gives code 1 and skips the error bank read. A set error bit gives code 2.
- R7: `err` is sticky for the walk. `err_code` and `err_word` keep the first problem found, the walk still visits the remaining words, and all three are cleared when a new walk starts. Code 0 means no error.
- R8: Each wait (power up, busy, power down) lasts at most CLK_MHZ*TIMEOUT_US cycles, counted from its first cycle. If its condition has not been seen by the last of those cycles, the walk aborts with code 3 on the current word and `done` rises. A condition seen on that last cycle counts as success.
- R9: An access completes only in a cycle where `bus_gnt` is high. Until then `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a new walk when idle |
| bus_gnt | input | 1 | Completes the presented access this cycle |
| bus_rdata | input | 32 | Read data of the presented access, valid with grant |
| bus_req | output | 1 | An access is presented |
| bus_we | output | 1 | Presented access is a write |
| bus_addr | output | 12 | Register byte offset of the access |
| bus_wdata | output | 32 | Write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk has finished |
| err | output | 1 | Sticky error flag of the last walk |
| err_code | output | 2 | 0 none, 1 disturbed, 2 error flag, 3 timeout |
| err_word | output | 7 | Word index of the first error |

## Verification
The collision that matters is a wait condition arriving in the very cycle the shared timeout counter reaches its last count. Success must win there, while one cycle later must abort. The bench provokes this by giving one chosen word a busy time of exactly the budget minus one cycle, and then exactly the budget, with the grant held high so the poll cycles are fixed. The two runs are judged at the ports: the first must end cleanly with all 39 commands, and the second must report code 3 on that word with no command after it. A second overlap, a `start` pulse landing mid-walk, is judged by the command log staying strictly ascending with no restart.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOCK, ST_PCHK, ST_PON, ST_WUP, ST_CMD,
    ST_WBSY, ST_DIST, ST_ERRB, ST_POFF, ST_WDN, ST_NEXT
  } fsr_state_e;

  typedef enum logic [1:0] {
    EC_NONE    = 2'd0,
    EC_DISTURB = 2'd1,
    EC_FLAGGED = 2'd2,
    EC_TIMEOUT = 2'd3
  } fsr_code_e;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // register offsets decoded by the fuse controller
  localparam logic [ADDR_W-1:0] OFS_CFG   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_DIST  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_ERRB  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_RLOCK = 12'h094;

  localparam int STAT_PWR_BIT  = 5;
  localparam int STAT_BUSY_BIT = 3;
  localparam int CFG_PWR_BIT   = 0;
  localparam int CTL_PROG_BIT  = 8;

  // byte offset of the 32-bit bank word that holds a given fuse word
  function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base,
                                                  input int unsigned word);
    int unsigned ofs;
    ofs = (word >> 5) << 2;
    return base + ofs[ADDR_W-1:0];
  endfunction

  // flag of a fuse word inside its bank word
  function automatic logic bit_pick(input logic [DATA_W-1:0] data,
                                    input int unsigned word);
    logic [4:0] idx;
    idx = word[4:0];
    return data[idx];
  endfunction

  function automatic int unsigned timeout_cycles(input int unsigned mhz,
                                                 input int unsigned us);
    return mhz * us;
  endfunction

  // read command: index in low bits, program bit left clear
  function automatic logic [DATA_W-1:0] read_cmd(input int unsigned word);
    logic [DATA_W-1:0] v;
    v = word;
    v[CTL_PROG_BIT] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/fsr_word_walker.sv
module fsr_word_walker #(
  parameter int FIRST_WORD = 57,
  parameter int LAST_WORD  = 95,
  parameter int WORD_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [WORD_W-1:0] word,
  output logic              at_last
);

  localparam logic [WORD_W-1:0] FIRST_V = WORD_W'(FIRST_WORD);
  localparam logic [WORD_W-1:0] LAST_V  = WORD_W'(LAST_WORD);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= FIRST_V;
    else if (load) word_q <= FIRST_V;
    else if (step) word_q <= word_q + 1'b1;
  end

  assign word    = word_q;
  assign at_last = (word_q == LAST_V);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) && !$past(load) |-> word_q == $past(word_q) + 1'b1);

  // R2
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_q >= FIRST_V && word_q <= LAST_V);

endmodule

// File: rtl/fsr_wait_timer.sv
module fsr_wait_timer #(
  parameter int unsigned LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // cleared whenever no wait is active, so each wait starts from zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LAST_V) cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_V);

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);

  // R8
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0);

endmodule

// File: rtl/fsr_err_log.sv
module fsr_err_log #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rec,
  input  logic [1:0]        code_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              err,
  output logic [1:0]        code,
  output logic [WORD_W-1:0] word
);

  logic              err_q;
  logic [1:0]        code_q;
  logic [WORD_W-1:0] word_q;
  logic              first_hit;

  assign first_hit = rec && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= 2'd0;
      word_q <= '0;
    end else if (clr) begin
      err_q  <= 1'b0;
      code_q <= 2'd0;
      word_q <= '0;
    end else if (first_hit) begin
      err_q  <= 1'b1;
      code_q <= code_in;
      word_q <= word_in;
    end
  end

  assign err  = err_q;
  assign code = code_q;
  assign word = word_q;

  // R7
  first_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) && !$past(clr) |-> $stable(code_q) && $stable(word_q) && err_q);

  // R7
  code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q == (code_q != 2'd0));

endmodule

// File: rtl/fuse_shadow_refresh.sv
module fuse_shadow_refresh
  import fsr_pkg::*;
#(
  parameter int FIRST_WORD = 57,
  parameter int LAST_WORD  = 95,
  parameter int CLK_MHZ    = 250,
  parameter int TIMEOUT_US = 10000,
  parameter int WORD_W     = $clog2(LAST_WORD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bus_gnt,
  input  logic [31:0]       bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [11:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic [WORD_W-1:0] err_word
);

  localparam int unsigned TO_CYC = timeout_cycles(CLK_MHZ, TIMEOUT_US);

  fsr_state_e        state_q, state_d;
  logic              armed_q, done_q, own_q;
  logic [WORD_W-1:0] word;
  logic              word_last, word_load, word_step;
  logic              log_clr, log_rec;
  fsr_code_e         log_code;
  logic              own_set, own_clr, done_set, done_clr, armed_clr;

  // named events used by the transitions and the assertions
  logic xfer, kick, in_wait, wait_ok, timer_last, tmo;
  logic lock_hit, dist_hit, eflag_hit, stat_pwr, stat_busy;
  int unsigned word_u;

  assign word_u    = 32'(word);
  assign xfer      = bus_req && bus_gnt;
  assign kick      = armed_q || start;
  assign stat_pwr  = bus_rdata[STAT_PWR_BIT];
  assign stat_busy = bus_rdata[STAT_BUSY_BIT];
  assign lock_hit  = bit_pick(bus_rdata, word_u);
  assign dist_hit  = bit_pick(bus_rdata, word_u);
  assign eflag_hit = bit_pick(bus_rdata, word_u);
  assign in_wait   = (state_q == ST_WUP) || (state_q == ST_WBSY) || (state_q == ST_WDN);

  always_comb begin
    case (state_q)
      ST_WUP:  wait_ok = xfer && stat_pwr;
      ST_WBSY: wait_ok = xfer && !stat_busy;
      ST_WDN:  wait_ok = xfer && !stat_pwr;
      default: wait_ok = 1'b0;
    endcase
  end

  // success seen on the final budget cycle takes priority
  assign tmo = timer_last && !wait_ok;

  fsr_word_walker #(
    .FIRST_WORD(FIRST_WORD), .LAST_WORD(LAST_WORD), .WORD_W(WORD_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(word_load), .step(word_step),
    .word(word), .at_last(word_last)
  );

  fsr_wait_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .last(timer_last)
  );

  fsr_err_log #(.WORD_W(WORD_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(log_clr), .rec(log_rec),
    .code_in(log_code), .word_in(word),
    .err(err), .code(err_code), .word(err_word)
  );

  // bus presentation, a pure function of the state and word
  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = OFS_STAT;
    bus_wdata = '0;
    case (state_q)
      ST_LOCK: bus_addr = bank_addr(OFS_RLOCK, word_u);
      ST_PCHK, ST_WUP, ST_WBSY, ST_WDN: bus_addr = OFS_STAT;
      ST_PON: begin
        bus_we = 1'b1;
        bus_addr = OFS_CFG;
        bus_wdata[CFG_PWR_BIT] = 1'b1;
      end
      ST_POFF: begin
        bus_we = 1'b1;
        bus_addr = OFS_CFG;
      end
      ST_CMD: begin
        bus_we = 1'b1;
        bus_addr = OFS_CTL;
        bus_wdata = read_cmd(word_u);
      end
      ST_DIST: bus_addr = bank_addr(OFS_DIST, word_u);
      ST_ERRB: bus_addr = bank_addr(OFS_ERRB, word_u);
      default: bus_req = 1'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    word_load = 1'b0;
    word_step = 1'b0;
    log_clr   = 1'b0;
    log_rec   = 1'b0;
    log_code  = EC_NONE;
    own_set   = 1'b0;
    own_clr   = 1'b0;
    done_set  = 1'b0;
    done_clr  = 1'b0;
    armed_clr = 1'b0;
    case (state_q)
      ST_IDLE: if (kick) begin
        state_d   = ST_LOCK;
        word_load = 1'b1;
        log_clr   = 1'b1;
        own_clr   = 1'b1;
        done_clr  = 1'b1;
        armed_clr = 1'b1;
      end
      ST_LOCK: if (xfer) state_d = lock_hit ? ST_NEXT : ST_PCHK;
      ST_PCHK: if (xfer) begin
        if (stat_pwr) state_d = ST_CMD;
        else begin
          state_d = ST_PON;
          own_set = 1'b1;
        end
      end
      ST_PON:  if (xfer) state_d = ST_WUP;
      ST_CMD:  if (xfer) state_d = ST_WBSY;
      ST_POFF: if (xfer) state_d = ST_WDN;
      ST_WUP, ST_WBSY, ST_WDN: begin
        if (wait_ok) begin
          if (state_q == ST_WUP)       state_d = ST_CMD;
          else if (state_q == ST_WBSY) state_d = ST_DIST;
          else begin
            state_d = ST_NEXT;
            own_clr = 1'b1;
          end
        end else if (tmo) begin
          state_d  = ST_IDLE;
          log_rec  = 1'b1;
          log_code = EC_TIMEOUT;
          done_set = 1'b1;
        end
      end
      ST_DIST: if (xfer) begin
        if (dist_hit) begin
          log_rec  = 1'b1;
          log_code = EC_DISTURB;
          state_d  = own_q ? ST_POFF : ST_NEXT;
        end else begin
          state_d = ST_ERRB;
        end
      end
      ST_ERRB: if (xfer) begin
        if (eflag_hit) begin
          log_rec  = 1'b1;
          log_code = EC_FLAGGED;
        end
        state_d = own_q ? ST_POFF : ST_NEXT;
      end
      ST_NEXT: begin
        if (word_last) begin
          state_d  = ST_IDLE;
          done_set = 1'b1;
        end else begin
          state_d   = ST_LOCK;
          word_step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      own_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (armed_clr) armed_q <= 1'b0;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (own_set)      own_q <= 1'b1;
      else if (own_clr) own_q <= 1'b0;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R1
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R2
  cmd_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == OFS_CTL) |-> !bus_wdata[CTL_PROG_BIT]);

  // R3
  lock_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && xfer && lock_hit) |=> state_q == ST_NEXT);

  // R4
  pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_NEXT |-> !own_q);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBSY && xfer && stat_busy) |=> (state_q == ST_WBSY || state_q == ST_IDLE));

  // R6
  dist_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIST && xfer && dist_hit) |=> state_q != ST_ERRB);

  // R8
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (done && err));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !tmo) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

endmodule

// File: tb/fuse_shadow_refresh_bench.sv
module fuse_shadow_refresh_bench;

  localparam int FW = 57;
  localparam int LW = 95;
  localparam int TO = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bus_gnt = 1'b1;
  logic [31:0] bus_rdata;
  logic bus_req, bus_we, busy, done, err;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0] err_code;
  logic [6:0] err_word;

  always #2 clk = ~clk;

  fuse_shadow_refresh #(.FIRST_WORD(FW), .LAST_WORD(LW), .CLK_MHZ(250), .TIMEOUT_US(1))
  u_fuse_shadow_refresh (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done(done), .err(err), .err_code(err_code), .err_word(err_word)
  );

  // fuse controller model
  logic [127:0] lockm = '0, distm = '0, errm = '0;
  int bdly = 2, slow_word = -1, slow_dly = 0;
  logic init_pwr = 1'b0, ld = 1'b1, gnt_toggle = 1'b0;
  logic cfg;
  logic [2:0] psr;
  int bcnt, cmd_cnt, last_cmd, pon_cnt, poff_cnt;
  logic order_bad, lock_bad, hold_bad, held;
  logic [11:0] held_addr;

  function automatic logic [31:0] bank_of(input logic [127:0] m, input int b);
    return m[b*32 +: 32];
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 12'h00C) begin
      bus_rdata[5] = psr[2];
      bus_rdata[3] = (bcnt != 0);
    end else if (bus_addr >= 12'h01C && bus_addr <= 12'h024)
      bus_rdata = bank_of(distm, int'((bus_addr - 12'h01C) >> 2));
    else if (bus_addr >= 12'h034 && bus_addr <= 12'h03C)
      bus_rdata = bank_of(errm, int'((bus_addr - 12'h034) >> 2));
    else if (bus_addr >= 12'h094 && bus_addr <= 12'h09C)
      bus_rdata = bank_of(lockm, int'((bus_addr - 12'h094) >> 2));
  end

  always @(posedge clk) begin
    int w;
    if (ld) begin
      cfg <= init_pwr; psr <= {3{init_pwr}}; bcnt <= 0;
      cmd_cnt <= 0; last_cmd <= -1; pon_cnt <= 0; poff_cnt <= 0;
      order_bad <= 0; lock_bad <= 0; hold_bad <= 0; held <= 0; held_addr <= '0;
    end else begin
      psr <= {psr[1:0], cfg};
      if (bcnt > 0) bcnt <= bcnt - 1;
      if (held && !(bus_req && bus_addr == held_addr)) hold_bad <= 1;
      held <= bus_req && !bus_gnt;
      held_addr <= bus_addr;
      if (bus_req && bus_gnt && bus_we) begin
        if (bus_addr == 12'h000) begin
          cfg <= bus_wdata[0];
          if (bus_wdata[0]) pon_cnt <= pon_cnt + 1; else poff_cnt <= poff_cnt + 1;
        end else if (bus_addr == 12'h004) begin
          w = int'(bus_wdata[6:0]);
          cmd_cnt <= cmd_cnt + 1;
          if (w <= last_cmd || w < FW || w > LW || bus_wdata[8]) order_bad <= 1;
          if (lockm[w]) lock_bad <= 1;
          last_cmd <= w;
          bcnt <= (w == slow_word) ? slow_dly : bdly;
        end
      end
    end
  end

  always @(negedge clk) bus_gnt <= gnt_toggle ? ~bus_gnt : 1'b1;

  int total = 0, bad = 0;
  logic wd_fired = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected outcome from the requirements
  task automatic predict(output int ncmd, output int code, output int fw, output int lastw);
    ncmd = 0; code = 0; fw = 0; lastw = -1;
    for (int w = FW; w <= LW; w++) begin
      if (lockm[w]) continue;
      ncmd++; lastw = w;
      if (w == slow_word && slow_dly >= TO) begin
        if (code == 0) begin code = 3; fw = w; end
        break;
      end
      if (code == 0) begin
        if (distm[w]) begin code = 1; fw = w; end
        else if (errm[w]) begin code = 2; fw = w; end
      end
    end
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 30000) begin @(negedge clk); n++; end
    if (n >= 30000) begin wd_fired = 1'b1; chk(1'b0, "watchdog", n, 0); end
  endtask

  task automatic launch(input logic mid_start);
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_done();
  endtask

  task automatic judge(input string tag, input logic full);
    int ncmd, code, fw, lastw;
    predict(ncmd, code, fw, lastw);
    chk(done && !busy, {tag, " R1 done"}, int'(done), 1);
    chk(cmd_cnt == ncmd, {tag, " R2 command count"}, cmd_cnt, ncmd);
    chk(!order_bad, {tag, " R2 ascending"}, int'(order_bad), 0);
    chk(!lock_bad, {tag, " R3 locked word skipped"}, int'(lock_bad), 0);
    chk(int'(err_code) == code, {tag, " R6 R7 code"}, int'(err_code), code);
    chk(err == (code != 0), {tag, " R7 flag"}, int'(err), int'(code != 0));
    if (code != 0) chk(int'(err_word) == fw, {tag, " R7 word"}, int'(err_word), fw);
    if (ncmd > 0) chk(last_cmd == lastw, {tag, " R2 last word"}, last_cmd, lastw);
    chk(!hold_bad, {tag, " R9 held request"}, int'(hold_bad), 0);
    if (full) begin
      chk(pon_cnt == (init_pwr ? 0 : ncmd), {tag, " R4 power-up writes"}, pon_cnt, init_pwr ? 0 : ncmd);
      chk(poff_cnt == pon_cnt, {tag, " R4 power-down writes"}, poff_cnt, pon_cnt);
      chk(psr[2] == init_pwr, {tag, " R4 power restored"}, int'(psr[2]), int'(init_pwr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && !err, "R1 reset state", int'({busy, done, bus_req, err}), 0);
    rst_n = 1'b1;
    @(negedge clk); ld = 1'b0;
    wait_done();
    judge("auto-run", 1'b1);

    // locks, power already on, toggling grant, start mid-walk ignored
    for (int w = FW; w <= LW; w++) lockm[w] = (w % 3 == 0);
    lockm[95] = 1'b1;
    init_pwr = 1'b1; gnt_toggle = 1'b1;
    launch(1'b1);
    judge("locked-poweron", 1'b1);

    lockm = '0; init_pwr = 1'b0; gnt_toggle = 1'b0;
    errm[58] = 1; distm[60] = 1; errm[70] = 1;
    launch(1'b0);
    judge("mixed-flags", 1'b1);

    errm = '0; distm = '0;
    lockm[58] = 1; lockm[59] = 1; lockm[60] = 1;
    errm[59] = 1; errm[61] = 1; distm[61] = 1;
    launch(1'b0);
    judge("dist-over-err", 1'b1);

    errm = '0; distm = '0;
    for (int w = FW; w <= LW; w++) lockm[w] = 1'b1;
    launch(1'b0);
    judge("all-locked", 1'b1);

    // R8 boundary: busy clears on the final budget cycle
    lockm = '0; slow_word = 65; slow_dly = TO - 1;
    launch(1'b0);
    judge("R8 last-cycle success", 1'b1);

    slow_dly = TO;
    launch(1'b0);
    judge("R8 timeout", 1'b0);

    slow_word = -1; slow_dly = 0;
    launch(1'b0);
    judge("R7 cleared on restart", 1'b1);

    // sweep: one flagged word at every position, grant alternating
    for (int w = FW; w <= LW; w++) begin
      distm = '0; errm = '0;
      gnt_toggle = w[0];
      if (w % 2 == 1) distm[w] = 1'b1; else errm[w] = 1'b1;
      if (w < LW) errm[w+1] = 1'b1;
      launch(1'b0);
      judge("sweep", 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule